// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block gathers a set of peripheral interrupt request lines and three system exception requests and presents at most one winner to a processor core. Each peripheral line is first qualified by a source-side mask and then captured as pending on a rising edge. It takes part in arbitration only while its controller enable bit is set. Software turns enables on and off through two separate write-one ports. It picks one of four priority levels per line through an 8-bit field, of which only the top two bits are stored.

The core sees a registered request made of a valid flag, a source index and a priority rank. The core acknowledges the request that is on offer. The acknowledge clears that source's pending bit, saves the running priority on a small nesting stack and makes the granted rank the running one. An end-of-interrupt restores the saved rank. A request is offered only when its rank is strictly better than the running rank, so equal or worse requests wait until the running handler finishes.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After synchronous reset, `req_valid` is 0, all enables read 0, all priority levels read 0, no source is pending, no handler is running (running rank 7) and the nesting stack is empty.
- R2: A write to address 0 sets every enable bit whose data bit is 1. A write to address 1 clears every enable bit whose data bit is 1. Zero data bits change nothing. Reading either address returns the enable mask in bits [NUM_LINES-1:0].
- R3: Address 2+w holds the priority of lines 4w..4w+3. Line 4w+b uses byte b, and only bits [8b+7:8b+6] are stored as its level 0..3 (values 0, 64, 128, 192). On readback the six low bits of each byte and unused bytes read 0.
- R4: A peripheral line becomes pending on a rising edge of `irq_lines & src_mask`. A line whose mask bit is 0 never becomes pending. Changing the mask while the line is low creates no pending.
- R5: Ranks are encoded as 0..2 for system exceptions and 3+level for peripheral lines, and a lower rank wins. Among pending, enabled lines of equal rank, the lowest index wins.
- R6: System request bit k (0 reset-class, 1 non-maskable, 2 fault) is edge-captured. It is reported with index NUM_LINES+k and rank k, ignores the enable bits and beats every peripheral line.
- R7: A request is offered only if its rank is strictly lower than the running rank. Requests of equal or higher rank stay pending.
- R8: `core_ack` while `req_valid` is 1 clears the granted source's pending bit, pushes the running rank, makes the granted rank the running one and drives `req_valid` low for the following cycle. `core_ack` while `req_valid` is 0 has no effect.
- R9: `core_eoi` pops the stack and restores the saved running rank. It has no effect on an empty stack, and it is ignored in a cycle where an acknowledge is taken.
- R10: The stack holds NEST_DEPTH saved ranks. While it is full, no request is offered.
- R11: Clearing the enable of a pending line removes it from arbitration but keeps it pending, and enabling it again offers it again.
- R12: A request rising before clock edge E is captured at E and appears on the outputs after edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Peripheral request lines |
| src_mask | input | NUM_LINES | Source-side mask, 1 lets the line through |
| sys_req | input | 3 | System exception requests (reset-class, non-maskable, fault) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| core_ack | input | 1 | Core takes the offered request |
| core_eoi | input | 1 | Core finishes the running handler |
| req_valid | output | 1 | A request is offered |
| req_index | output | 6 | Offered source index |
| req_rank | output | 3 | Offered priority rank |

## Verification
The bench builds the block with its defaults: 32 lines and a nesting depth of 5. With 32 lines every priority word and every enable bit is used, so a readback checks the full mask and all eight level words. A depth of 5 is just small enough that a chain of four peripheral levels followed by one system exception fills the stack. That makes it possible to reach the full-stack block and its release on end-of-interrupt, along with ties, preemption and disabled pending lines under random traffic.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int IDX_W   = 6;
    localparam int RANK_W  = 3;
    localparam int SYS_CNT = 3;
    localparam int MAX_LINES = 32;

    typedef logic [RANK_W-1:0] rank_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam rank_t RANK_IDLE   = 3'd7;
    localparam rank_t RANK_P_BASE = 3'd3;

    typedef struct packed {
        logic  valid;
        idx_t  index;
        rank_t rank;
    } grant_t;

    function automatic rank_t periph_rank(input logic [1:0] lvl);
        return RANK_P_BASE + rank_t'(lvl);
    endfunction

    function automatic rank_t sys_rank(input int k);
        return rank_t'(k);
    endfunction

endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
    import nic_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic [NUM_LINES-1:0]        enable,
    output logic [NUM_LINES-1:0][1:0]   level
);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(1);
    localparam int PRIO_BASE = 2;

    logic [NUM_LINES-1:0]      en_q;
    logic [NUM_LINES-1:0][1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            lvl_q <= '0;
        end else if (we) begin
            if (addr == A_SET)
                en_q <= en_q | wdata[NUM_LINES-1:0];
            else if (addr == A_CLR)
                en_q <= en_q & ~wdata[NUM_LINES-1:0];
            for (int i = 0; i < NUM_LINES; i++) begin
                if (addr == ADDR_W'(PRIO_BASE + i / 4))
                    lvl_q[i] <= wdata[8 * (i % 4) + 6 +: 2];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_SET || addr == A_CLR)
            rdata[NUM_LINES-1:0] = en_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (addr == ADDR_W'(PRIO_BASE + i / 4))
                rdata[8 * (i % 4) + 6 +: 2] = lvl_q[i];
        end
    end

    assign enable = en_q;
    assign level  = lvl_q;

endmodule

// File: rtl/nic_pending.sv
module nic_pending
    import nic_pkg::*;
#(
    parameter int N_SRC = 35
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req_in,
    input  logic             clr_vld,
    input  idx_t             clr_idx,
    output logic [N_SRC-1:0] pend
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic prev_q;
        logic pend_q;
        logic hit;

        assign hit = clr_vld && (clr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= req_in[g];
                pend_q <= (pend_q & ~hit) | (req_in[g] & ~prev_q);
            end
        end

        assign pend[g] = pend_q;
    end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic [NUM_LINES+SYS_CNT-1:0] pend,
    input  logic [NUM_LINES-1:0]         enable,
    input  logic [NUM_LINES-1:0][1:0]    level,
    input  rank_t                        active,
    input  logic                         stack_full,
    output grant_t                       cand
);
    rank_t best_rank;
    idx_t  best_idx;
    rank_t r;

    always_comb begin
        best_rank = RANK_IDLE;
        best_idx  = '0;
        r         = RANK_IDLE;
        for (int i = 0; i < NUM_LINES; i++) begin
            r = periph_rank(level[i]);
            if (pend[i] && enable[i] && r < best_rank) begin
                best_rank = r;
                best_idx  = IDX_W'(i);
            end
        end
        for (int k = 0; k < SYS_CNT; k++) begin
            if (pend[NUM_LINES + k] && sys_rank(k) < best_rank) begin
                best_rank = sys_rank(k);
                best_idx  = IDX_W'(NUM_LINES + k);
            end
        end
        cand.valid = (best_rank != RANK_IDLE) && (best_rank < active) && !stack_full;
        cand.index = best_idx;
        cand.rank  = best_rank;
    end

endmodule

// File: rtl/nic_nest_stack.sv
module nic_nest_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  rank_t            push_rank,
    input  logic             pop,
    output rank_t            active,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    rank_t            stk_q [DEPTH];
    rank_t            act_q;
    logic [CNT_W-1:0] cnt_q;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= RANK_IDLE;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= RANK_IDLE;
        end else if (push && !full) begin
            stk_q[cnt_q] <= act_q;
            act_q        <= push_rank;
            cnt_q        <= cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            act_q <= stk_q[cnt_q - CNT_W'(1)];
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign active = act_q;
    assign count  = cnt_q;

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NEST_DEPTH = 5,
    parameter int ADDR_W     = $clog2((NUM_LINES + 3) / 4 + 2)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [NUM_LINES-1:0] src_mask,
    input  logic [2:0]           sys_req,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 core_ack,
    input  logic                 core_eoi,
    output logic                 req_valid,
    output logic [5:0]           req_index,
    output logic [2:0]           req_rank
);
    localparam int N_SRC = NUM_LINES + SYS_CNT;
    localparam int CNT_W = $clog2(NEST_DEPTH + 1);

    if (NUM_LINES > MAX_LINES || NUM_LINES < 1) begin : g_bad_cfg
        $error("NUM_LINES out of range");
    end

    logic [NUM_LINES-1:0]      enable;
    logic [NUM_LINES-1:0][1:0] level;
    logic [N_SRC-1:0]          pend;
    logic [N_SRC-1:0]          req_in;
    rank_t                     active_rank;
    logic                      stack_full;
    logic                      stack_empty;
    logic [CNT_W-1:0]          nest_cnt;
    grant_t                    cand;
    grant_t                    out_q;
    logic                      ack_fire;
    logic                      eoi_fire;

    assign req_in   = {sys_req, irq_lines & src_mask};
    assign ack_fire = core_ack & out_q.valid;
    assign eoi_fire = core_eoi & ~ack_fire & ~stack_empty;

    nic_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .enable (enable),
        .level  (level)
    );

    nic_pending #(.N_SRC(N_SRC)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .req_in  (req_in),
        .clr_vld (ack_fire),
        .clr_idx (out_q.index),
        .pend    (pend)
    );

    nic_nest_stack #(.DEPTH(NEST_DEPTH), .CNT_W(CNT_W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (ack_fire),
        .push_rank (out_q.rank),
        .pop       (eoi_fire),
        .active    (active_rank),
        .full      (stack_full),
        .empty     (stack_empty),
        .count     (nest_cnt)
    );

    nic_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
        .pend       (pend),
        .enable     (enable),
        .level      (level),
        .active     (active_rank),
        .stack_full (stack_full),
        .cand       (cand)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '{valid: 1'b0, index: '0, rank: RANK_IDLE};
        end else if (ack_fire || eoi_fire) begin
            out_q.valid <= 1'b0;
        end else begin
            out_q <= cand;
        end
    end

    assign req_valid = out_q.valid;
    assign req_index = out_q.index;
    assign req_rank  = out_q.rank;

endmodule

// File: rtl/nic_checker.sv
module nic_checker
    import nic_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NEST_DEPTH = 5,
    parameter int CNT_W      = $clog2(NEST_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             core_ack,
    input logic             core_eoi,
    input logic             req_valid,
    input logic [5:0]       req_index,
    input logic [2:0]       req_rank,
    input logic [2:0]       active_rank,
    input logic [CNT_W-1:0] nest_cnt
);
    // R7
    strict_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_rank < active_rank);

    // R8
    ack_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (core_ack && req_valid) |=> !req_valid);

    // R8
    ack_sets_active_chk: assert property (@(posedge clk) disable iff (rst)
        (core_ack && req_valid) |=> active_rank == $past(req_rank));

    // R9
    eoi_ignored_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (core_ack && req_valid && core_eoi) |=> nest_cnt == $past(nest_cnt) + CNT_W'(1));

    // R9
    idle_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        nest_cnt == '0 |-> active_rank == RANK_IDLE);

    // R10
    nest_bound_chk: assert property (@(posedge clk) disable iff (rst)
        nest_cnt <= CNT_W'(NEST_DEPTH));

    // R10
    full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        nest_cnt == CNT_W'(NEST_DEPTH) |-> !req_valid);

    // R6
    sys_rank_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(req_index) >= NUM_LINES)
            |-> (int'(req_rank) == int'(req_index) - NUM_LINES) && (int'(req_index) < NUM_LINES + SYS_CNT));

    // R5
    periph_rank_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(req_index) < NUM_LINES) |-> req_rank >= RANK_P_BASE);

endmodule

bind nested_irq_ctrl nic_checker #(
    .NUM_LINES  (NUM_LINES),
    .NEST_DEPTH (NEST_DEPTH),
    .CNT_W      (CNT_W)
) u_nic_checker (
    .clk         (clk),
    .rst         (rst),
    .core_ack    (core_ack),
    .core_eoi    (core_eoi),
    .req_valid   (req_valid),
    .req_index   (req_index),
    .req_rank    (req_rank),
    .active_rank (active_rank),
    .nest_cnt    (nest_cnt)
);

// File: tb/test_nested_irq_ctrl.sv
`timescale 1ns/1ps
module test_nested_irq_ctrl;
    localparam int NL    = 32;
    localparam int DEPTH = 5;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] irq_lines = '0;
    logic [NL-1:0] src_mask  = '1;
    logic [2:0]    sys_req   = '0;
    logic          reg_we    = 1'b0;
    logic [AW-1:0] reg_addr  = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          core_ack  = 1'b0;
    logic          core_eoi  = 1'b0;
    logic          req_valid;
    logic [5:0]    req_index;
    logic [2:0]    req_rank;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bit [NL+2:0] m_pend;
    bit [NL-1:0] m_en;
    int          m_lvl [NL];
    int          m_active;
    int          m_stk [DEPTH];
    int          m_cnt;

    always #5 clk = ~clk;

    nested_irq_ctrl #(.NUM_LINES(NL), .NEST_DEPTH(DEPTH), .ADDR_W(AW)) i_nested_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .src_mask  (src_mask),
        .sys_req   (sys_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .core_ack  (core_ack),
        .core_eoi  (core_eoi),
        .req_valid (req_valid),
        .req_index (req_index),
        .req_rank  (req_rank)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        m_pend = '0; m_en = '0; m_active = 7; m_cnt = 0;
        for (int i = 0; i < NL; i++) m_lvl[i] = 0;
        for (int i = 0; i < DEPTH; i++) m_stk[i] = 7;
    endtask

    task automatic do_reset();
        rst = 1'b1; irq_lines = '0; sys_req = '0; reg_we = 1'b0;
        core_ack = 1'b0; core_eoi = 1'b0;
        tick(3);
        rst = 1'b0;
        model_reset();
        tick(1);
    endtask

    function automatic void exp_grant(output bit v, output int idx, output int rk);
        int best = 7;
        int bi = 0;
        for (int i = 0; i < NL; i++)
            if (m_pend[i] && m_en[i] && 3 + m_lvl[i] < best) begin best = 3 + m_lvl[i]; bi = i; end
        for (int k = 0; k < 3; k++)
            if (m_pend[NL + k] && k < best) begin best = k; bi = NL + k; end
        v = (best != 7) && (best < m_active) && (m_cnt < DEPTH);
        idx = bi;
        rk = best;
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] d = '0;
        for (int b = 0; b < 4; b++)
            if (4 * w + b < NL) d[8 * b + 6 +: 2] = 2'(m_lvl[4 * w + b]);
        return d;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        tick(1);
        reg_we = 1'b0;
        if (a == 0) m_en = m_en | d[NL-1:0];
        else if (a == 1) m_en = m_en & ~d[NL-1:0];
        else for (int b = 0; b < 4; b++)
            if (4 * (a - 2) + b < NL) m_lvl[4 * (a - 2) + b] = int'(d[8 * b + 6 +: 2]);
    endtask

    task automatic rd_check(input int a, input logic [31:0] exp, input string tag);
        reg_addr = AW'(a);
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic pulse_lines(input logic [NL-1:0] m);
        irq_lines = m;
        tick(1);
        irq_lines = '0;
        for (int i = 0; i < NL; i++) if (m[i] && src_mask[i]) m_pend[i] = 1'b1;
    endtask

    task automatic pulse_sys(input logic [2:0] m);
        sys_req = m;
        tick(1);
        sys_req = '0;
        for (int k = 0; k < 3; k++) if (m[k]) m_pend[NL + k] = 1'b1;
    endtask

    task automatic model_ack();
        bit v; int idx; int rk;
        exp_grant(v, idx, rk);
        if (v) begin
            m_pend[idx] = 1'b0;
            m_stk[m_cnt] = m_active;
            m_cnt++;
            m_active = rk;
        end
    endtask

    task automatic do_ack();
        core_ack = 1'b1;
        tick(1);
        core_ack = 1'b0;
        model_ack();
    endtask

    task automatic do_eoi();
        core_eoi = 1'b1;
        tick(1);
        core_eoi = 1'b0;
        if (m_cnt > 0) begin m_cnt--; m_active = m_stk[m_cnt]; end
    endtask

    task automatic check_out(input string tag);
        bit v; int idx; int rk;
        tick(3);
        exp_grant(v, idx, rk);
        chk(req_valid == v, {tag, " valid"}, req_valid, v);
        if (v) begin
            chk(int'(req_index) == idx, {tag, " index"}, req_index, idx);
            chk(int'(req_rank) == rk, {tag, " rank"}, req_rank, rk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        src_mask = '1;
        src_mask[10] = 1'b0;
        do_reset();

        // R1 reset state
        chk(req_valid == 1'b0, "R1 valid after reset", req_valid, 0);
        rd_check(0, 32'h0, "R1 enable after reset");
        rd_check(2, 32'h0, "R1 priority after reset");

        // R2 set/clear enable
        wr(0, 32'h0000_0F0F);
        rd_check(0, 32'h0000_0F0F, "R2 set readback");
        rd_check(1, 32'h0000_0F0F, "R2 clear-port readback");
        wr(1, 32'h0000_0003);
        rd_check(0, 32'h0000_0F0C, "R2 clear ones");
        wr(0, 32'h0);
        wr(1, 32'h0);
        rd_check(0, 32'h0000_0F0C, "R2 zeros no effect");

        // R3 priority fields
        wr(2, 32'hFFFF_FFFF);
        rd_check(2, 32'hC0C0_C0C0, "R3 top bits only");
        wr(4, 32'h0000_40BF);
        rd_check(4, 32'h0000_4080, "R3 word 2 levels");

        // R12 latency: line 3 (rank 6)
        irq_lines[3] = 1'b1;
        tick(1);
        irq_lines[3] = 1'b0;
        m_pend[3] = 1'b1;
        chk(req_valid == 1'b0, "R12 not yet visible", req_valid, 0);
        tick(1);
        chk(req_valid == 1'b1 && req_index == 6'd3, "R12 visible after second edge",
            {req_valid, req_index}, {1'b1, 6'd3});

        // R5 tie: line 2 also rank 6
        pulse_lines(32'h4);
        check_out("R5 tie");
        chk(req_index == 6'd2, "R5 tie lowest index", req_index, 2);
        // R5 lower rank: line 8 rank 5
        pulse_lines(32'h100);
        check_out("R5 lower rank");
        chk(req_index == 6'd8 && req_rank == 3'd5, "R5 line 8 wins", {req_index, req_rank}, {6'd8, 3'd5});

        // R4 masked line 10 never pending
        pulse_lines(32'h400);
        check_out("R4 masked pulse");
        chk(req_index == 6'd8, "R4 masked line not offered", req_index, 8);
        src_mask[10] = 1'b1;
        check_out("R4 mask change no edge");
        chk(req_index == 6'd8, "R4 unmask without edge", req_index, 8);

        // R11 disable keeps pending
        wr(1, 32'h100);
        check_out("R11 disabled");
        chk(req_index == 6'd2, "R11 next winner", req_index, 2);
        wr(0, 32'h100);
        check_out("R11 reenabled");
        chk(req_index == 6'd8, "R11 pending kept", req_index, 8);

        // R8 ack
        core_ack = 1'b1;
        tick(1);
        core_ack = 1'b0;
        model_ack();
        chk(req_valid == 1'b0, "R8 valid low after ack", req_valid, 0);
        check_out("R7 worse stays pending");
        chk(req_valid == 1'b0, "R7 rank 6 below running 5", req_valid, 0);

        // R7 preemption by line 11 (rank 3)
        pulse_lines(32'h800);
        check_out("R7 preempt");
        chk(req_valid && req_index == 6'd11, "R7 strict preempt", req_index, 11);
        do_ack();
        wr(0, 32'h1000);
        pulse_lines(32'h1000);
        check_out("R7 equal rank");
        chk(req_valid == 1'b0, "R7 equal rank waits", req_valid, 0);

        // R8 ack with nothing offered
        do_ack();
        check_out("R8 ignored ack");

        // R6 system exceptions
        pulse_sys(3'b010);
        check_out("R6 nmi");
        chk(req_index == 6'd33 && req_rank == 3'd1, "R6 nmi index/rank", {req_index, req_rank}, {6'd33, 3'd1});
        do_ack();
        pulse_sys(3'b001);
        check_out("R6 reset-class preempt");
        chk(req_index == 6'd32 && req_rank == 3'd0, "R6 reset-class", {req_index, req_rank}, {6'd32, 3'd0});
        do_ack();
        pulse_sys(3'b100);
        check_out("R7 fault waits");

        // R9 eoi
        do_eoi();
        check_out("R9 pop one");
        do_eoi();
        check_out("R9 pop two");
        chk(req_valid && req_index == 6'd34, "R9 fault after restore", req_index, 34);
        core_ack = 1'b1; core_eoi = 1'b1;
        tick(1);
        core_ack = 1'b0; core_eoi = 1'b0;
        model_ack();
        check_out("R9 ack beats eoi");
        for (int i = 0; i < 6; i++) do_eoi();
        check_out("R9 empty eoi ignored");
        chk(req_valid && req_index == 6'd12, "R9 idle after unwinding", req_index, 12);

        // R10 stack full
        do_reset();
        src_mask = '1;
        wr(0, 32'hF);
        wr(2, 32'h0040_80C0);
        for (int i = 0; i < 4; i++) begin
            pulse_lines(NL'(1) << i);
            check_out("R10 chain");
            do_ack();
        end
        pulse_sys(3'b100);
        check_out("R10 chain fault");
        do_ack();
        pulse_sys(3'b010);
        check_out("R10 full");
        chk(req_valid == 1'b0, "R10 full blocks nmi", req_valid, 0);
        do_eoi();
        check_out("R10 released");
        chk(req_valid && req_index == 6'd33, "R10 nmi after pop", req_index, 33);

        // Random phase
        do_reset();
        src_mask = '1;
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            case (op)
                0, 1, 2: pulse_lines($urandom & $urandom & $urandom);
                3: begin wr(0, $urandom & $urandom); rd_check(0, 32'(m_en), "R2 random enable"); end
                4: wr(1, $urandom & $urandom);
                5: begin
                    int w = $urandom_range(2, 9);
                    wr(w, $urandom);
                    rd_check(w, exp_word(w - 2), "R3 random priority");
                end
                6, 7: do_ack();
                8: do_eoi();
                default: begin
                    if ($urandom_range(0, 3) == 0) pulse_sys(3'($urandom));
                    else src_mask = $urandom | $urandom;
                end
            endcase
            check_out("R5 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule